// File: doc/BRIEF.md
# Late-Write Synchronous Burst Memory

This block is a clocked single-port memory whose data phase always runs exactly one cycle behind its command phase. A command (single read, single write, burst continue, stop or no-op) is taken at a rising edge. In the cycle after it, the block either drives the addressed word with the output enable high, or captures the write data on the next edge. Because writes also complete one cycle late, a read can follow a write with no idle cycle in between. The 36-bit word is split into four 9-bit byte lanes, and each lane has its own active-low write enable.

A burst starts with a load command that carries an external address. Each later cycle with the advance input high steps a 2-bit counter through an interleaved order. Only the two low address bits follow this order, and the direction of the burst (read or write) is fixed when it is loaded. A high clock-enable-bar at an edge freezes the block completely. The data bus is modelled as a separate input, a separate output and an output enable.

The control is a three-state data-phase machine. PH_IDLE means no data phase is pending. PH_READ means read data is on the bus. PH_WRITE means write data will be captured at the next enabled edge. Each enabled edge decodes one command:
- LOAD_RD goes to PH_READ and LOAD_WR goes to PH_WRITE. Both arm a burst.
- CONT repeats the armed burst kind.
- STOP goes to PH_IDLE and disarms the burst.
- NOOP goes to PH_IDLE.
- HOLD, the suspended edge, keeps every state as it is.

Top module: `lw_burst_sram`

## Requirements
- R1: At an edge with cen_n=0, the chip selected and adv=0, the block loads `addr`. With rw=1 the command is a read: in the following cycle rdata_oe=1 and rdata holds the word at that address. With rw=0 the command is a write.
- R2: For a write command, the block captures wdata and bw_n at the next edge with cen_n=0, and stores the enabled lanes at the command's address.
- R3: The chip is selected only when ce1_n=0, ce2_n=0 and ce2=1. Every other combination counts as deselected.
- R4: An edge with adv=0 while deselected is a stop. In the following cycle rdata_oe=0, and nothing is written.
- R5: An edge with adv=1 during a live burst ignores ce1_n, ce2_n, ce2 and rw. The burst steps to its next address and repeats the operation kind that was latched at the load.
- R6: An edge with adv=1 when no burst is live is a no-op. No burst is live after reset or after a stop. In the cycle after a no-op, rdata_oe=0.
- R7: The low two address bits follow an interleaved order. From a start value s, the k-th address (k=0,1,2,...) is s XOR (k mod 4), so after four steps the sequence wraps.
- R8: An edge with cen_n=1 changes nothing. The memory contents, rdata_oe, rdata and the burst position all keep their values.
- R9: Lane i is bits [9i+8:9i] of the word and is written only when bw_n[i]=0. When bw_n=4'b1111, a write cycle stores nothing.
- R10: In the data phase of a read, bw_n and wdata have no effect on the memory.
- R11: During a burst, address bits [AW-1:2] stay as loaded. There is no carry into them.
- R12: After reset, rdata_oe=0 and no data phase is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all commands are taken at the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cen_n | input | 1 | Active-low clock enable; when high, the edge is ignored |
| rw | input | 1 | Operation of a load command: 1 = read, 0 = write |
| ce1_n | input | 1 | Chip enable, active low |
| ce2_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| adv | input | 1 | 0 = load or stop, 1 = advance the burst |
| addr | input | AW | Word address used by a load command |
| bw_n | input | NLANES | Active-low lane write enables, sampled in the data phase |
| wdata | input | NLANES*LANE_W | Write data, sampled in the data phase |
| rdata | output | NLANES*LANE_W | Read data for the current data phase |
| rdata_oe | output | 1 | High while read data is driven on the bus |

## Verification
The assertions check four things on every cycle: a load-read raises the output enable in the next cycle, a stop or a no-op drops it, a suspended edge leaves the outputs and the burst position untouched, and a burst step keeps the upper address bits while changing the low two. Only the bench scenarios can show the data itself. These scenarios cover the interleaved address order and its wrap, the late capture of write data and lane masks, reads that follow writes with no gap, and a write data phase stretched across a suspend. They compare every read word against a reference array that the bench keeps.

// File: rtl/lwsram_pkg.sv
`timescale 1ns/1ps
package lwsram_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        CMD_HOLD    = 3'd0,
        CMD_LOAD_RD = 3'd1,
        CMD_LOAD_WR = 3'd2,
        CMD_STOP    = 3'd3,
        CMD_CONT    = 3'd4,
        CMD_NOOP    = 3'd5
    } cmd_e;
endpackage

// File: rtl/lwsram_ctrl.sv
`timescale 1ns/1ps
module lwsram_ctrl
    import lwsram_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cen_n,
    input  logic   rw,
    input  logic   sel,
    input  logic   adv,
    output phase_e phase,
    output logic   burst_live,
    output logic   do_load,
    output logic   do_step,
    output logic   wr_commit,
    output logic   rd_drive
);
    cmd_e   cmd;
    phase_e phase_d;
    phase_e kind_q, kind_d;
    logic   live_d;

    // command decode for this edge
    always_comb begin
        if (cen_n)
            cmd = CMD_HOLD;
        else if (!adv)
            cmd = sel ? (rw ? CMD_LOAD_RD : CMD_LOAD_WR) : CMD_STOP;
        else
            cmd = burst_live ? CMD_CONT : CMD_NOOP;
    end

    // next-state logic
    always_comb begin
        phase_d = phase;
        kind_d  = kind_q;
        live_d  = burst_live;
        unique case (cmd)
            CMD_HOLD: begin
            end
            CMD_LOAD_RD: begin
                phase_d = PH_READ;
                kind_d  = PH_READ;
                live_d  = 1'b1;
            end
            CMD_LOAD_WR: begin
                phase_d = PH_WRITE;
                kind_d  = PH_WRITE;
                live_d  = 1'b1;
            end
            CMD_STOP: begin
                phase_d = PH_IDLE;
                live_d  = 1'b0;
            end
            CMD_CONT: begin
                phase_d = kind_q;
            end
            CMD_NOOP: begin
                phase_d = PH_IDLE;
            end
            default: begin
                phase_d = PH_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            kind_q     <= PH_IDLE;
            burst_live <= 1'b0;
        end else begin
            phase      <= phase_d;
            kind_q     <= kind_d;
            burst_live <= live_d;
        end
    end

    // outputs
    always_comb begin
        do_load   = (cmd == CMD_LOAD_RD) || (cmd == CMD_LOAD_WR);
        do_step   = (cmd == CMD_CONT);
        wr_commit = !cen_n && (phase == PH_WRITE);
        rd_drive  = (phase == PH_READ);
    end

    // R6
    noop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv && !burst_live) |=> (phase == PH_IDLE));

    // R5
    cont_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv && burst_live) |=> (phase == $past(phase)) && (phase != PH_IDLE));
endmodule

// File: rtl/lwsram_burst_ctr.sv
`timescale 1ns/1ps
module lwsram_burst_ctr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cmd_addr
);
    localparam int UW = AW - 2;

    logic [UW-1:0] upper_q;
    logic [1:0]    start_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_nx;

    assign cnt_nx = cnt_q + 2'd1;

    always_comb begin
        if (load)
            cmd_addr = addr_in;
        else
            cmd_addr = {upper_q, start_q ^ cnt_nx};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            upper_q <= addr_in[AW-1:2];
            start_q <= addr_in[1:0];
            cnt_q   <= '0;
        end else if (step) begin
            cnt_q   <= cnt_nx;
        end
    end
endmodule

// File: rtl/lwsram_array.sv
`timescale 1ns/1ps
module lwsram_array #(
    parameter int AW     = 6,
    parameter int NLANES = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [NLANES*LANE_W-1:0] wdata,
    input  logic [NLANES-1:0]        bw_n,
    input  logic [AW-1:0]            raddr,
    output logic [NLANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !bw_n[g])
                lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/lw_burst_sram.sv
`timescale 1ns/1ps
module lw_burst_sram
    import lwsram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int NLANES = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cen_n,
    input  logic                     rw,
    input  logic                     ce1_n,
    input  logic                     ce2_n,
    input  logic                     ce2,
    input  logic                     adv,
    input  logic [AW-1:0]            addr,
    input  logic [NLANES-1:0]        bw_n,
    input  logic [NLANES*LANE_W-1:0] wdata,
    output logic [NLANES*LANE_W-1:0] rdata,
    output logic                     rdata_oe
);
    localparam int DW = NLANES * LANE_W;

    logic          selected;
    phase_e        phase;
    logic          burst_live;
    logic          do_load;
    logic          do_step;
    logic          wr_commit;
    logic          rd_drive;
    logic [AW-1:0] cmd_addr;
    logic [AW-1:0] phase_addr;
    logic [DW-1:0] arr_rdata;

    assign selected = !ce1_n && !ce2_n && ce2;

    lwsram_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cen_n      (cen_n),
        .rw         (rw),
        .sel        (selected),
        .adv        (adv),
        .phase      (phase),
        .burst_live (burst_live),
        .do_load    (do_load),
        .do_step    (do_step),
        .wr_commit  (wr_commit),
        .rd_drive   (rd_drive)
    );

    lwsram_burst_ctr #(.AW(AW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .step     (do_step),
        .addr_in  (addr),
        .cmd_addr (cmd_addr)
    );

    // address of the pending data phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_addr <= '0;
        else if (do_load || do_step)
            phase_addr <= cmd_addr;
    end

    lwsram_array #(.AW(AW), .NLANES(NLANES), .LANE_W(LANE_W)) u_arr (
        .clk   (clk),
        .we    (wr_commit),
        .waddr (phase_addr),
        .wdata (wdata),
        .bw_n  (bw_n),
        .raddr (phase_addr),
        .rdata (arr_rdata)
    );

    assign rdata    = arr_rdata;
    assign rdata_oe = rd_drive;

    // R1
    load_read_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv && selected && rw) |=> rdata_oe);

    // R4
    stop_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv && !selected) |=> !rdata_oe);

    // R8
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(rdata_oe) && $stable(rdata) && $stable(phase_addr));

    // R11
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv && burst_live) |=>
            (phase_addr[AW-1:2] == $past(phase_addr[AW-1:2])) &&
            (phase_addr[1:0] != $past(phase_addr[1:0])));
endmodule

// File: tb/sim_lw_burst_sram.sv
`timescale 1ns/1ps
module sim_lw_burst_sram;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;
    localparam int DW = 36;
    localparam logic [2:0] SEL = 3'b001;
    localparam logic [2:0] DES = 3'b110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cen_n = 1'b0, rw = 1'b1, ce1_n = 1'b1, ce2_n = 1'b1, ce2 = 1'b0, adv = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [3:0]    bw_n = 4'hF;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    int nchk = 0;
    int nfail = 0;
    logic [DW-1:0] refm [DEPTH];

    always #4 clk = ~clk;

    lw_burst_sram u0 (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .rw(rw), .ce1_n(ce1_n),
        .ce2_n(ce2_n), .ce2(ce2), .adv(adv), .addr(addr), .bw_n(bw_n),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'((a + 1) * 36'h0_1357_9BDF) ^ DW'(salt * 36'h3_0F0F_1234) ^ 36'h9_A5C3_0F1E;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [3:0] b);
        logic [DW-1:0] r;
        r = old;
        for (int i = 0; i < 4; i++)
            if (!b[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    task automatic step(input logic c, input logic r, input logic [2:0] ce, input logic a_v,
                        input logic [AW-1:0] ad, input logic [3:0] b, input logic [DW-1:0] d);
        @(negedge clk);
        cen_n = c; rw = r; {ce1_n, ce2_n, ce2} = ce; adv = a_v;
        addr = ad; bw_n = b; wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_read(input string req, input logic [AW-1:0] a);
        chk(rdata_oe === 1'b1, req, {35'd0, rdata_oe}, 36'd1);
        chk(rdata === refm[a], req, rdata, refm[a]);
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
            $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk(rdata_oe === 1'b0, "R12 oe after reset", {35'd0, rdata_oe}, 36'd0);
        rst_n = 1'b1;
        // R6: advance right after reset is a no-op
        step(0, 1, SEL, 1, 6'd5, 4'h0, '0);
        chk(rdata_oe === 1'b0, "R6 noop after reset", {35'd0, rdata_oe}, 36'd0);

        // R1 R2: fill with back-to-back single writes
        for (int a = 0; a < DEPTH; a++) begin
            step(0, 0, SEL, 0, AW'(a), 4'h0, (a > 0) ? pat(a - 1, 0) : '0);
            if (a > 0) refm[a - 1] = pat(a - 1, 0);
        end
        step(0, 1, DES, 0, '0, 4'h0, pat(DEPTH - 1, 0));
        refm[DEPTH - 1] = pat(DEPTH - 1, 0);
        chk(rdata_oe === 1'b0, "R4 oe low after stop", {35'd0, rdata_oe}, 36'd0);

        // R1: back-to-back reads of the whole array
        for (int a = 0; a < DEPTH; a++) begin
            step(0, 1, SEL, 0, AW'(a), 4'h0, '1);
            chk_read("R1 single read", AW'(a));
        end
        step(0, 1, DES, 0, '0, 4'hF, '0);

        // R3 R4: chip-select sweep on reads and writes
        for (int cs = 0; cs < 8; cs++) begin
            step(0, 1, 3'(cs), 0, 6'd9, 4'hF, '0);
            if (cs == 1) chk_read("R3 selected read", 6'd9);
            else chk(rdata_oe === 1'b0, "R3 deselected read", {35'd0, rdata_oe}, 36'd0);
            step(0, 0, 3'(cs), 0, 6'd10, 4'hF, '0);
            step(0, 1, DES, 0, '0, 4'h0, pat(10, cs + 7));
            if (cs == 1) refm[10] = pat(10, cs + 7);
            step(0, 1, SEL, 0, 6'd10, 4'hF, '0);
            chk_read("R4 write only when selected", 6'd10);
            step(0, 1, DES, 0, '0, 4'hF, '0);
        end

        // R6: advance after stop is a no-op
        step(0, 1, SEL, 1, 6'd3, 4'h0, '0);
        chk(rdata_oe === 1'b0, "R6 noop after stop", {35'd0, rdata_oe}, 36'd0);
        step(0, 0, SEL, 1, 6'd3, 4'h0, '1);
        chk(rdata_oe === 1'b0, "R6 second noop", {35'd0, rdata_oe}, 36'd0);
        step(0, 1, SEL, 0, 6'd3, 4'hF, '0);
        chk_read("R6 noop stored nothing", 6'd3);

        // R5 R7 R8 R11: read bursts from every start, with a wrap and a suspend
        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] base;
            base = 6'b101100 | AW'(s);
            step(0, 1, SEL, 0, base, 4'hF, '0);
            chk_read("R7 burst first", base);
            for (int k = 1; k <= 5; k++) begin
                logic [AW-1:0] ea;
                ea = {base[AW-1:2], 2'(s) ^ 2'(k % 4)};
                step(0, 0, DES, 1, 6'd0, 4'h0, '1);
                chk_read("R7 R11 R5 interleaved burst read", ea);
                if (k == 2) begin
                    step(1, 0, SEL, 0, 6'd1, 4'h0, '1);
                    chk_read("R8 suspend holds read", ea);
                    step(1, 1, SEL, 1, 6'd2, 4'h0, '1);
                    chk_read("R8 suspend holds read again", ea);
                end
            end
            step(0, 1, DES, 0, '0, 4'hF, '0);
        end

        // R5 R7 R2: write burst with rw toggled during advances
        begin
            logic [AW-1:0] wb;
            wb = 6'b110001;
            step(0, 0, SEL, 0, wb, 4'hF, '0);
            for (int k = 1; k < 4; k++) begin
                step(0, 1, DES, 1, 6'd0, 4'h0, pat(k - 1, 40));
                refm[{wb[AW-1:2], 2'b01 ^ 2'(k - 1)}] = pat(k - 1, 40);
            end
            step(0, 1, DES, 0, '0, 4'h0, pat(3, 40));
            refm[{wb[AW-1:2], 2'b10}] = pat(3, 40);
            for (int k = 0; k < 4; k++) begin
                step(0, 1, SEL, 0, {wb[AW-1:2], 2'(k)}, 4'hF, '0);
                chk_read("R5 R7 burst write stored", {wb[AW-1:2], 2'(k)});
            end
        end

        // R8: suspend in a write data phase captures at the next live edge
        step(0, 0, SEL, 0, 6'd7, 4'h0, '0);
        step(1, 1, SEL, 0, 6'd8, 4'h0, pat(7, 99));
        step(0, 1, DES, 0, '0, 4'h0, pat(7, 55));
        refm[7] = pat(7, 55);
        step(0, 1, SEL, 0, 6'd7, 4'hF, '0);
        chk_read("R8 write across suspend", 6'd7);

        // R9 R2: every lane mask, read issued right after the write
        for (int m = 0; m < 16; m++) begin
            step(0, 0, SEL, 0, 6'd3, 4'h0, '0);
            step(0, 1, SEL, 0, 6'd3, 4'(m), pat(m, 77));
            refm[3] = merge(refm[3], pat(m, 77), 4'(m));
            chk_read("R9 lane mask write", 6'd3);
        end

        // R10: read data phase ignores lane enables and wdata
        step(0, 1, SEL, 0, 6'd3, 4'h0, '1);
        step(0, 1, SEL, 0, 6'd3, 4'h0, 36'h5_5555_5555);
        chk_read("R10 read ignores bw_n", 6'd3);
        step(0, 1, DES, 0, '0, 4'h0, '1);
        step(0, 1, SEL, 0, 6'd3, 4'hF, '0);
        chk_read("R10 memory unchanged", 6'd3);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule